// File: doc/BRIEF.md
# ALU with compare and move-high

This block is the combinational execute unit of a small 32-bit core. Each cycle it takes two operands that were already selected and sign-extended upstream, a 2-bit mode and a 4-bit function code. It returns a 32-bit result. In the two arithmetic/logic modes (register and immediate) the result is a sum, a difference or a bitwise value. Immediate mode also offers a move-high operation that builds the upper half of a constant.

In compare mode the result is 1 or 0, zero-extended to the full width, and the same truth value appears on a separate branch-taken output. The same compare codes serve compare-to-register instructions and conditional branches. Bit 3 of a compare code inverts the condition, so every test and its complement sit one code bit apart. The zero-test codes look only at the first operand.

Any code that has no meaning in the current mode gives a zero result and a clear branch output, and raises an invalid flag for the decoder to trap on. The block holds no state.

Top module: `alu_hm_core`

## Requirements
- R1: Mode encoding: register ALU is 00, immediate ALU is 01, compare is 10. In both ALU modes, code 0000 gives a+b and code 0001 gives a-b, modulo 2^32.
- R2: In both ALU modes, codes 0100, 0101 and 0110 give a AND b, a OR b and a XOR b.
- R3: In both ALU modes, codes 1100, 1101 and 1110 give NOT(a AND b), NOT(a OR b) and NOT(a XOR b).
- R4: In immediate mode only, code 1011 (move-high) gives b[15:0] in result bits 31:16 and zeros in bits 15:0. Operand a has no effect.
- R5: In compare mode, for a defined code, the result is 32'd1 when the condition holds and 32'd0 when it does not, and taken_o equals result bit 0. In both ALU modes taken_o is 0.
- R6: Compare codes 0000, 0001, 0010 and 0011 are always-false, a==b, signed a<b and signed a<=b.
- R7: Compare codes 1000, 1001, 1010 and 1011 are always-true, a!=b, signed a>=b and signed a>b. Each is the inverse of the code with bit 3 clear.
- R8: Compare codes 0101 (a==0), 0111 (signed a<=0), 1101 (a!=0) and 1111 (signed a>0) do not depend on b.
- R9: Mode 11, compare codes 0100, 0110, 1100 and 1110, and ALU codes outside R1–R4 (including 1011 in register mode) give result 0, taken_o 0 and invalid_o 1. invalid_o is 0 for every defined combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (register value or sign-extended immediate) |
| mode_i | input | 2 | 00 register ALU, 01 immediate ALU, 10 compare, 11 reserved |
| func_i | input | 4 | Function or condition code |
| result_o | output | 32 | ALU result or zero-extended compare outcome |
| taken_o | output | 1 | Condition outcome for branches (compare mode only) |
| invalid_o | output | 1 | Code undefined in the current mode |

## Verification
The checker's immediate assertions assume that all inputs carry known 0/1 values. They also assume the inputs are stable while the combinational outputs settle, so they are evaluated only once a full set of operands, mode and code has been applied. The bench changes inputs only on the rising edge and samples on the falling edge. It never drives X or Z. The random loop covers every mode value, including the reserved one, and every 4-bit code. About a third of the random cases force equal or zero operands, and directed cases add signed extremes so that the compare boundaries are reached.

// File: rtl/alu_hm_pkg.sv
package alu_hm_pkg;

    typedef enum logic [1:0] {
        MD_REG  = 2'b00,
        MD_IMM  = 2'b01,
        MD_CMP  = 2'b10,
        MD_RSVD = 2'b11
    } alu_mode_e;

    // arithmetic / logic codes
    localparam logic [3:0] FN_ADD  = 4'b0000;
    localparam logic [3:0] FN_SUB  = 4'b0001;
    localparam logic [3:0] FN_MVHI = 4'b1011;

    // compare base conditions (code bit 3 inverts)
    localparam logic [2:0] CB_FALSE = 3'b000;
    localparam logic [2:0] CB_EQ    = 3'b001;
    localparam logic [2:0] CB_LT    = 3'b010;
    localparam logic [2:0] CB_LE    = 3'b011;
    localparam logic [2:0] CB_EQZ   = 3'b101;
    localparam logic [2:0] CB_LEZ   = 3'b111;

endpackage

// File: rtl/alu_hm_addsub.sv
module alu_hm_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    end
endmodule

// File: rtl/alu_hm_logic.sv
module alu_hm_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   func_i,
    output logic [W-1:0] y_o,
    output logic         hit_o
);
    // func[2] selects the logic group, func[1:0] picks AND/OR/XOR, func[3] negates
    logic [1:0] sel;
    logic       neg;

    always_comb begin
        sel   = func_i[1:0];
        neg   = func_i[3];
        hit_o = func_i[2] && (sel != 2'b11);
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic base;
        always_comb begin
            unique case (sel)
                2'b00:   base = a_i[i] & b_i[i];
                2'b01:   base = a_i[i] | b_i[i];
                2'b10:   base = a_i[i] ^ b_i[i];
                default: base = 1'b0;
            endcase
            y_o[i] = hit_o ? (base ^ neg) : 1'b0;
        end
    end
endmodule

// File: rtl/alu_hm_cmp.sv
module alu_hm_cmp
    import alu_hm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   code_i,
    output logic         cond_o,
    output logic         hit_o
);
    logic eq_ab, lt_ab, eq_z, lt_z;
    logic base;

    always_comb begin
        eq_ab = (a_i == b_i);
        lt_ab = ($signed(a_i) < $signed(b_i));
        eq_z  = (a_i == '0);
        lt_z  = a_i[W-1];
        hit_o = 1'b1;
        unique case (code_i[2:0])
            CB_FALSE: base = 1'b0;
            CB_EQ:    base = eq_ab;
            CB_LT:    base = lt_ab;
            CB_LE:    base = lt_ab | eq_ab;
            CB_EQZ:   base = eq_z;
            CB_LEZ:   base = lt_z | eq_z;
            default: begin
                base  = 1'b0;
                hit_o = 1'b0;
            end
        endcase
        cond_o = hit_o & (base ^ code_i[3]);
    end
endmodule

// File: rtl/alu_hm_core.sv
module alu_hm_core
    import alu_hm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   mode_i,
    input  logic [3:0]   func_i,
    output logic [W-1:0] result_o,
    output logic         taken_o,
    output logic         invalid_o
);
    localparam int HALF = W / 2;

    logic [W-1:0] sum, lres, mvhi;
    logic         is_sub, l_hit, c_cond, c_hit;
    alu_mode_e    mode;

    always_comb begin
        mode   = alu_mode_e'(mode_i);
        is_sub = (func_i == FN_SUB);
        mvhi   = {b_i[HALF-1:0], {HALF{1'b0}}};
    end

    alu_hm_addsub #(.W(W)) addsub_i (
        .a_i(a_i), .b_i(b_i), .sub_i(is_sub), .sum_o(sum)
    );

    alu_hm_logic #(.W(W)) logic_i (
        .a_i(a_i), .b_i(b_i), .func_i(func_i), .y_o(lres), .hit_o(l_hit)
    );

    alu_hm_cmp #(.W(W)) cmp_i (
        .a_i(a_i), .b_i(b_i), .code_i(func_i), .cond_o(c_cond), .hit_o(c_hit)
    );

    always_comb begin
        result_o  = '0;
        taken_o   = 1'b0;
        invalid_o = 1'b0;
        unique case (mode)
            MD_REG, MD_IMM: begin
                if (func_i == FN_ADD || func_i == FN_SUB) begin
                    result_o = sum;
                end else if (l_hit) begin
                    result_o = lres;
                end else if (mode == MD_IMM && func_i == FN_MVHI) begin
                    result_o = mvhi;
                end else begin
                    invalid_o = 1'b1;
                end
            end
            MD_CMP: begin
                if (c_hit) begin
                    result_o = {{(W-1){1'b0}}, c_cond};
                    taken_o  = c_cond;
                end else begin
                    invalid_o = 1'b1;
                end
            end
            default: invalid_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/alu_hm_chk.sv
module alu_hm_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [1:0]   mode_i,
    input logic [3:0]   func_i,
    input logic [W-1:0] result_o,
    input logic         taken_o,
    input logic         invalid_o
);
    always_comb begin
        // R9: an undefined code drives every output to its quiet value
        if (invalid_o)
            a_r9_invalid_quiet: assert (result_o == '0 && !taken_o);
        // R9: the reserved mode is always flagged
        if (mode_i == 2'b11)
            a_r9_rsvd_mode: assert (invalid_o);
        // R5: a compare result is 0 or 1 and agrees with the branch output
        if (mode_i == 2'b10 && !invalid_o)
            a_r5_cmp_bool: assert (result_o[W-1:1] == '0 && result_o[0] == taken_o);
        // R5: no branch outcome outside compare mode
        if (mode_i != 2'b10)
            a_r5_no_taken: assert (!taken_o);
        // R4: move-high leaves the low half clear
        if (mode_i == 2'b01 && func_i == 4'b1011)
            a_r4_mvhi_low_zero: assert (result_o[W/2-1:0] == '0 && !invalid_o);
        // R1: a difference plus b recovers a
        if (mode_i[1] == 1'b0 && func_i == 4'b0001)
            a_r1_sub_inverse: assert (result_o + b_i == a_i);
        // R7: always-true taken, always-false not
        if (mode_i == 2'b10 && func_i == 4'b1000)
            a_r7_true: assert (taken_o);
        if (mode_i == 2'b10 && func_i == 4'b0000)
            a_r6_false: assert (!taken_o && result_o == '0);
    end
endmodule

bind alu_hm_core alu_hm_chk #(.W(W)) chk_i (.*);

// File: tb/alu_hm_core_tb.sv
module alu_hm_core_tb_top;

    logic        clk = 1'b0;
    logic [31:0] a, b, res;
    logic [1:0]  mode;
    logic [3:0]  func;
    logic        taken, inval;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    alu_hm_core dut_i (
        .a_i(a), .b_i(b), .mode_i(mode), .func_i(func),
        .result_o(res), .taken_o(taken), .invalid_o(inval)
    );

    // reference model written from the requirements
    function automatic void model(input logic [1:0] m, input logic [3:0] f,
                                  input logic [31:0] x, input logic [31:0] y,
                                  output logic [31:0] r, output logic t,
                                  output logic iv, output string tag);
        logic c;
        r = '0; t = 1'b0; iv = 1'b0; tag = "R9"; c = 1'b0;
        if (m == 2'b00 || m == 2'b01) begin
            case (f)
                4'b0000: begin r = x + y;    tag = "R1"; end
                4'b0001: begin r = x - y;    tag = "R1"; end
                4'b0100: begin r = x & y;    tag = "R2"; end
                4'b0101: begin r = x | y;    tag = "R2"; end
                4'b0110: begin r = x ^ y;    tag = "R2"; end
                4'b1100: begin r = ~(x & y); tag = "R3"; end
                4'b1101: begin r = ~(x | y); tag = "R3"; end
                4'b1110: begin r = ~(x ^ y); tag = "R3"; end
                4'b1011: if (m == 2'b01) begin r = {y[15:0], 16'h0}; tag = "R4"; end
                         else iv = 1'b1;
                default: iv = 1'b1;
            endcase
        end else if (m == 2'b10) begin
            case (f)
                4'b0000: begin c = 1'b0; tag = "R6"; end
                4'b0001: begin c = (x == y); tag = "R6"; end
                4'b0010: begin c = ($signed(x) <  $signed(y)); tag = "R6"; end
                4'b0011: begin c = ($signed(x) <= $signed(y)); tag = "R6"; end
                4'b1000: begin c = 1'b1; tag = "R7"; end
                4'b1001: begin c = (x != y); tag = "R7"; end
                4'b1010: begin c = ($signed(x) >= $signed(y)); tag = "R7"; end
                4'b1011: begin c = ($signed(x) >  $signed(y)); tag = "R7"; end
                4'b0101: begin c = (x == 0); tag = "R8"; end
                4'b0111: begin c = ($signed(x) <= 0); tag = "R8"; end
                4'b1101: begin c = (x != 0); tag = "R8"; end
                4'b1111: begin c = ($signed(x) > 0); tag = "R8"; end
                default: iv = 1'b1;
            endcase
            if (!iv) begin r = {31'h0, c}; t = c; end
        end else begin
            iv = 1'b1;
        end
    endfunction

    task automatic apply(input logic [1:0] m, input logic [3:0] f,
                         input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er; logic et, ei; string tg;
        @(posedge clk);
        mode = m; func = f; a = x; b = y;
        @(negedge clk);
        model(m, f, x, y, er, et, ei, tg);
        checks++;
        if (res !== er || taken !== et || inval !== ei) begin
            errors++;
            $display("FAIL %s (R5 outputs) mode=%b func=%b a=%h b=%h : got res=%h tk=%b inv=%b exp res=%h tk=%b inv=%b",
                     tg, m, f, x, y, res, taken, inval, er, et, ei);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        logic [31:0] r0, r1;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        a = '0; b = '0; mode = 2'b00; func = 4'b0000;
        // initial state: add of zeros
        apply(2'b00, 4'b0000, 32'h0, 32'h0);                      // R1
        apply(2'b00, 4'b0000, 32'hFFFF_FFFF, 32'h1);              // R1 wrap
        apply(2'b01, 4'b0001, 32'h0, 32'h1);                      // R1 borrow
        apply(2'b00, 4'b1100, 32'hF0F0_1234, 32'hFF00_FFFF);      // R3
        apply(2'b00, 4'b0110, 32'hAAAA_5555, 32'h5555_AAAA);      // R2
        apply(2'b01, 4'b1011, 32'hDEAD_BEEF, 32'hFFFF_8001);      // R4
        apply(2'b00, 4'b1011, 32'hDEAD_BEEF, 32'h0000_8001);      // R9 reg-mode mvhi
        apply(2'b10, 4'b0010, 32'h8000_0000, 32'h7FFF_FFFF);      // R6 signed lt
        apply(2'b10, 4'b1011, 32'h7FFF_FFFF, 32'h8000_0000);      // R7 gt
        apply(2'b10, 4'b0011, 32'h1234_5678, 32'h1234_5678);      // R6 le equal
        apply(2'b10, 4'b1010, 32'h1234_5678, 32'h1234_5678);      // R7 ge equal
        apply(2'b10, 4'b0111, 32'h0, 32'h8000_0000);              // R8 lez at zero
        apply(2'b10, 4'b1111, 32'h0000_0001, 32'h7FFF_FFFF);      // R8 gtz
        apply(2'b10, 4'b0110, 32'h1, 32'h1);                      // R9 cmp hole
        apply(2'b11, 4'b0000, 32'h5, 32'h6);                      // R9 rsvd mode
        // R8: b must not change zero-test outputs
        for (int k = 0; k < 16; k++) begin
            logic [3:0] zc;
            logic [31:0] ra, ta;
            zc = (k % 4 == 0) ? 4'b0101 : (k % 4 == 1) ? 4'b0111 :
                 (k % 4 == 2) ? 4'b1101 : 4'b1111;
            ra = (k < 8) ? 32'h0 : $urandom;
            apply(2'b10, zc, ra, $urandom);
            r0 = res; ta = {31'h0, taken};
            apply(2'b10, zc, ra, ~b);
            r1 = res;
            checks++;
            if (r0 !== r1 || ta[0] !== taken) begin
                errors++;
                $display("FAIL R8 b changed result: got %h/%h exp %h", r1, r0, r0);
            end
        end
        // random mix
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] x, y;
            int sel;
            x = $urandom; y = $urandom;
            sel = $urandom_range(0, 5);
            if (sel == 0) y = x;
            if (sel == 1) x = 32'h0;
            apply(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), x, y);
        end
        finish_run();
    end

endmodule